// File: doc/BRIEF.md
# Host Indirect Memory Access Port

This block lets an external host reach the on-chip program and data memories over a 16-bit multiplexed address/data bus. The host side runs with no relation to the core clock. The core may keep running while the host uses the port. Every host strobe passes through a two-flop synchroniser before the port acts on it.

A host session has two steps. First the host pulses the address latch strobe, which loads a 14-bit start address and a space bit that picks data memory (16-bit words) or program memory (24-bit words). Then the host makes any number of read or write transfers, each framed by the select strobe together with the read or write strobe. The port holds its acknowledge low while a transfer is in progress. It raises the acknowledge once the transfer is done. After each access the port advances the latched address, so a sequential block needs only its start address. A program word is carried as two bus transfers. On the core side the port issues one memory request at a time with a simple request/grant handshake. Read data arrives one cycle after the grant.

Top module: `host_mem_port`

## Requirements
- R1: After reset, hst_ack is 1, mem_req is 0 and hst_ad_oe is 0.
- R2: When hst_latch falls and the port is idle with hst_ack high, the port loads the address from hst_ad_i[13:0] and the space from hst_ad_i[14] (0 = data memory, 1 = program memory). hst_ad_i[15] is ignored.
- R3: A fall of hst_latch while hst_ack is low is ignored. The latched address and space keep their values.
- R4: A transfer starts when hst_sel_n is low together with hst_rd_n low or hst_wr_n low; if both are low, the transfer is a write. hst_ack goes low after the synchronised start and returns high only after the access has completed.
- R5: A data-space write stores hst_ad_i as mem_wdata[15:0] with mem_wdata[23:16] = 0, at the latched address, with mem_space = 0 and mem_we = 1.
- R6: A data-space read returns mem_rdata[15:0] on hst_ad_o by the time hst_ack rises.
- R7: After every data-space access the address advances by one. It wraps from 0x3FFF to 0x0000.
- R8: A program-space write takes two transfers. The first carries word bits 23:8 and causes no memory access. The second carries word bits 7:0 in hst_ad_i[7:0], with hst_ad_i[15:8] ignored, and causes one 24-bit memory write. The address advances only after the second transfer.
- R9: A program-space read takes two transfers but makes only one memory read, on the first transfer. The first transfer returns word bits 23:8. The second returns {8'h00, word bits 7:0}. The address advances after the second transfer.
- R10: While mem_req is high and mem_gnt is low, mem_req, mem_addr, mem_we and mem_wdata stay unchanged.
- R11: hst_ad_oe is high during a read transfer, including the cycle in which hst_ack rises. It is low again once the strobes are released.
- R12: A new address latch restarts the program-word pairing at its first (upper) transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| hst_latch | input | 1 | Host address latch strobe; the address is taken on its falling edge |
| hst_sel_n | input | 1 | Host select, active low |
| hst_rd_n | input | 1 | Host read strobe, active low |
| hst_wr_n | input | 1 | Host write strobe, active low |
| hst_ad_i | input | 16 | Multiplexed address/data bus from the host |
| hst_ad_o | output | 16 | Read data to the host |
| hst_ad_oe | output | 1 | Drive enable for hst_ad_o |
| hst_ack | output | 1 | Acknowledge: high when the port is free, low while a transfer is in progress |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Request is a write |
| mem_space | output | 1 | 0 = data memory, 1 = program memory |
| mem_addr | output | 14 | Word address of the request |
| mem_wdata | output | 24 | Write data |
| mem_gnt | input | 1 | Grant; the access is taken in the cycle where mem_req and mem_gnt are both high |
| mem_rdata | input | 24 | Read data, valid one cycle after a read grant |

## Verification
Sequential data-memory bursts written and read back show whether the auto-increment and the 16-bit path work. A burst started at 0x3FFE separates correct 14-bit wrapping from an overflow into a wider counter. Program-word pairs whose second transfer carries junk in the upper byte show whether the pairing order, the single memory access per word and the masking are right. A repeated latch after a lone upper half shows whether the pairing restarts. A latch pulse given while a grant is being held back separates a properly gated address load from an ungated one, and the same pulse shows whether the request stays stable. A long run of random spaces, start addresses and burst lengths, with random grant stalls, mixes all of these cases.

// File: rtl/hmp_pkg.sv
package hmp_pkg;
  typedef enum logic [2:0] {
    XS_IDLE,
    XS_REQ,
    XS_RDW,
    XS_FIN,
    XS_HOLD
  } hmp_st_e;

  localparam logic SPACE_DM = 1'b0;
  localparam logic SPACE_PM = 1'b1;
endpackage

// File: rtl/hmp_sync.sv
module hmp_sync #(
  parameter int             WIDTH   = 4,
  parameter int             STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/hmp_addr.sv
module hmp_addr
  import hmp_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic              ld_space,
  input  logic              step,
  output logic [ADDR_W-1:0] addr,
  output logic              space,
  output logic              half
);
  logic [ADDR_W-1:0] addr_q;
  logic              space_q;
  logic              half_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      space_q <= SPACE_DM;
      half_q  <= 1'b0;
    end else if (ld) begin
      addr_q  <= ld_addr;
      space_q <= ld_space;
      half_q  <= 1'b0;
    end else if (step) begin
      if (space_q == SPACE_PM && !half_q) begin
        half_q <= 1'b1;
      end else begin
        half_q <= 1'b0;
        addr_q <= addr_q + 1'b1;
      end
    end
  end

  assign addr  = addr_q;
  assign space = space_q;
  assign half  = half_q;

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    step && (space_q == SPACE_DM || half_q) |=> addr_q == $past(addr_q) + 1'b1); // R7
  AST_PM_FIRST_HALF: assert property (@(posedge clk) disable iff (rst)
    step && space_q == SPACE_PM && !half_q |=> $stable(addr_q) && half_q); // R8
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !ld && !step |=> $stable(addr_q) && $stable(space_q)); // R3
  AST_LOAD_PHASE: assert property (@(posedge clk) disable iff (rst)
    ld |=> !half_q); // R12
endmodule

// File: rtl/hmp_xfer.sv
module hmp_xfer
  import hmp_pkg::*;
#(
  parameter int BUS_W = 16,
  parameter int PM_W  = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_rise,
  input  logic             req_lvl,
  input  logic             is_wr,
  input  logic [BUS_W-1:0] bus_in,
  input  logic             space,
  input  logic             half,
  input  logic             mem_gnt,
  input  logic [PM_W-1:0]  mem_rdata,
  output logic             mem_req,
  output logic             mem_we,
  output logic [PM_W-1:0]  mem_wdata,
  output logic             ack,
  output logic             oe,
  output logic [BUS_W-1:0] rdata,
  output logic             step,
  output logic             idle
);
  localparam int LO_W  = PM_W - BUS_W;
  localparam int PAD_D = PM_W - BUS_W;
  localparam int PAD_L = BUS_W - LO_W;

  hmp_st_e           st_q;
  logic              wr_q;
  logic              ack_q;
  logic              oe_q;
  logic [BUS_W-1:0]  wr_hi_q;
  logic [LO_W-1:0]   rd_lo_q;
  logic [BUS_W-1:0]  rdata_q;
  logic [PM_W-1:0]   wdata_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= XS_IDLE;
      wr_q    <= 1'b0;
      ack_q   <= 1'b1;
      oe_q    <= 1'b0;
      wr_hi_q <= '0;
      rd_lo_q <= '0;
      rdata_q <= '0;
      wdata_q <= '0;
    end else begin
      unique case (st_q)
        XS_IDLE: begin
          if (req_rise) begin
            ack_q <= 1'b0;
            wr_q  <= is_wr;
            oe_q  <= !is_wr;
            if (space == SPACE_DM) begin
              wdata_q <= {{PAD_D{1'b0}}, bus_in};
              st_q    <= XS_REQ;
            end else if (is_wr) begin
              if (!half) begin
                wr_hi_q <= bus_in;
                st_q    <= XS_FIN;
              end else begin
                wdata_q <= {wr_hi_q, bus_in[LO_W-1:0]};
                st_q    <= XS_REQ;
              end
            end else begin
              if (!half) begin
                st_q <= XS_REQ;
              end else begin
                rdata_q <= {{PAD_L{1'b0}}, rd_lo_q};
                st_q    <= XS_FIN;
              end
            end
          end
        end
        XS_REQ: begin
          if (mem_gnt) st_q <= wr_q ? XS_FIN : XS_RDW;
        end
        XS_RDW: begin
          if (space == SPACE_DM) begin
            rdata_q <= mem_rdata[BUS_W-1:0];
          end else begin
            rdata_q <= mem_rdata[PM_W-1 -: BUS_W];
            rd_lo_q <= mem_rdata[LO_W-1:0];
          end
          st_q <= XS_FIN;
        end
        XS_FIN: begin
          ack_q <= 1'b1;
          st_q  <= XS_HOLD;
        end
        XS_HOLD: begin
          if (!req_lvl) begin
            oe_q <= 1'b0;
            st_q <= XS_IDLE;
          end
        end
        default: st_q <= XS_IDLE;
      endcase
    end
  end

  assign mem_req   = (st_q == XS_REQ);
  assign mem_we    = wr_q;
  assign mem_wdata = wdata_q;
  assign ack       = ack_q;
  assign oe        = oe_q;
  assign rdata     = rdata_q;
  assign step      = (st_q == XS_FIN);
  assign idle      = (st_q == XS_IDLE);

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_wdata) && $stable(mem_we)); // R10
  AST_ACK_BUSY: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !ack_q); // R4
  AST_OE_READ: assert property (@(posedge clk) disable iff (rst)
    oe_q |-> !wr_q); // R11
  AST_PM_LOW_LOCAL: assert property (@(posedge clk) disable iff (rst)
    idle && req_rise && space == SPACE_PM && half && !is_wr |=> !mem_req); // R9
endmodule

// File: rtl/host_mem_port.sv
module host_mem_port
  import hmp_pkg::*;
#(
  parameter int ADDR_W      = 14,
  parameter int BUS_W       = 16,
  parameter int PM_W        = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hst_latch,
  input  logic              hst_sel_n,
  input  logic              hst_rd_n,
  input  logic              hst_wr_n,
  input  logic [BUS_W-1:0]  hst_ad_i,
  output logic [BUS_W-1:0]  hst_ad_o,
  output logic              hst_ad_oe,
  output logic              hst_ack,
  output logic              mem_req,
  output logic              mem_we,
  output logic              mem_space,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [PM_W-1:0]   mem_wdata,
  input  logic              mem_gnt,
  input  logic [PM_W-1:0]   mem_rdata
);
  localparam int SPACE_BIT = ADDR_W;
  localparam int NSTROBE   = 4;

  logic [NSTROBE-1:0] strb_s;
  logic latch_s, sel_s_n, rd_s_n, wr_s_n;
  logic latch_prev, req_prev;
  logic req_s, req_rise, latch_fall, ld;
  logic step_w, idle_w, space_w, half_w;
  logic [ADDR_W-1:0] addr_w;

  hmp_sync #(
    .WIDTH  (NSTROBE),
    .STAGES (SYNC_STAGES),
    .RST_VAL(4'b1110)
  ) i_sync (
    .clk(clk),
    .rst(rst),
    .d  ({hst_sel_n, hst_rd_n, hst_wr_n, hst_latch}),
    .q  (strb_s)
  );

  assign sel_s_n = strb_s[3];
  assign rd_s_n  = strb_s[2];
  assign wr_s_n  = strb_s[1];
  assign latch_s = strb_s[0];

  assign req_s      = !sel_s_n && (!rd_s_n || !wr_s_n);
  assign req_rise   = req_s && !req_prev;
  assign latch_fall = !latch_s && latch_prev;
  assign ld         = latch_fall && hst_ack && idle_w;

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_prev <= 1'b0;
      req_prev   <= 1'b0;
    end else begin
      latch_prev <= latch_s;
      req_prev   <= req_s;
    end
  end

  hmp_addr #(
    .ADDR_W(ADDR_W)
  ) i_addr (
    .clk     (clk),
    .rst     (rst),
    .ld      (ld),
    .ld_addr (hst_ad_i[ADDR_W-1:0]),
    .ld_space(hst_ad_i[SPACE_BIT]),
    .step    (step_w),
    .addr    (addr_w),
    .space   (space_w),
    .half    (half_w)
  );

  hmp_xfer #(
    .BUS_W(BUS_W),
    .PM_W (PM_W)
  ) i_xfer (
    .clk      (clk),
    .rst      (rst),
    .req_rise (req_rise),
    .req_lvl  (req_s),
    .is_wr    (!wr_s_n),
    .bus_in   (hst_ad_i),
    .space    (space_w),
    .half     (half_w),
    .mem_gnt  (mem_gnt),
    .mem_rdata(mem_rdata),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_wdata(mem_wdata),
    .ack      (hst_ack),
    .oe       (hst_ad_oe),
    .rdata    (hst_ad_o),
    .step     (step_w),
    .idle     (idle_w)
  );

  assign mem_addr  = addr_w;
  assign mem_space = space_w;

  AST_LATCH_GATED: assert property (@(posedge clk) disable iff (rst)
    latch_fall && !hst_ack && !step_w |=> $stable(mem_addr) && $stable(mem_space)); // R3
  AST_ADDR_REQ_STABLE: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_gnt |=> $stable(mem_addr) && $stable(mem_space)); // R10
endmodule

// File: tb/test_host_mem_port.sv
module test_host_mem_port;
  logic        clk = 1'b0;
  logic        rst;
  logic        hst_latch, hst_sel_n, hst_rd_n, hst_wr_n;
  logic [15:0] hst_ad_i, hst_ad_o;
  logic        hst_ad_oe, hst_ack;
  logic        mem_req, mem_we, mem_space, mem_gnt;
  logic [13:0] mem_addr;
  logic [23:0] mem_wdata, mem_rdata;

  int total = 0;
  int bad = 0;
  int xfer_errs = 0;
  int wr_cnt = 0;
  int rd_cnt = 0;
  bit gnt_hold = 1'b0;
  bit last_oe;
  logic [23:0] dm_m [int];
  logic [23:0] pm_m [int];

  always #2.5 clk = ~clk;

  host_mem_port i_host_mem_port (
    .clk(clk), .rst(rst), .hst_latch(hst_latch), .hst_sel_n(hst_sel_n),
    .hst_rd_n(hst_rd_n), .hst_wr_n(hst_wr_n), .hst_ad_i(hst_ad_i),
    .hst_ad_o(hst_ad_o), .hst_ad_oe(hst_ad_oe), .hst_ack(hst_ack),
    .mem_req(mem_req), .mem_we(mem_we), .mem_space(mem_space),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_gnt(mem_gnt),
    .mem_rdata(mem_rdata)
  );

  function automatic logic [23:0] pat(input bit pm, input logic [13:0] a);
    if (pm) return 24'(a * 977 + 24'h0A0B0C);
    return {8'h00, 16'(a * 13 + 16'h1F)};
  endfunction

  function automatic logic [23:0] mget(input bit pm, input logic [13:0] a);
    if (pm) return pm_m.exists(int'(a)) ? pm_m[int'(a)] : pat(1'b1, a);
    return dm_m.exists(int'(a)) ? dm_m[int'(a)] : pat(1'b0, a);
  endfunction

  // memory model: grant and access decided at the negative edge
  initial begin
    mem_gnt = 1'b0;
    mem_rdata = '0;
    forever begin
      @(negedge clk);
      mem_gnt = gnt_hold ? 1'b0 : (($urandom % 3) != 0);
      if (mem_req && mem_gnt) begin
        if (mem_we) begin
          wr_cnt++;
          if (mem_space) pm_m[int'(mem_addr)] = mem_wdata;
          else dm_m[int'(mem_addr)] = mem_wdata;
        end else begin
          rd_cnt++;
          mem_rdata = mget(mem_space, mem_addr);
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [23:0] act, input logic [23:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic latch(input bit pm, input logic [13:0] a, input bit b15);
    @(negedge clk);
    hst_ad_i = {b15, pm, a};
    hst_latch = 1'b1;
    repeat (4) @(negedge clk);
    hst_latch = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic xfer(input bit wr, input logic [15:0] d, output logic [15:0] q);
    int t;
    @(negedge clk);
    hst_ad_i = d;
    hst_sel_n = 1'b0;
    if (wr) hst_wr_n = 1'b0; else hst_rd_n = 1'b0;
    t = 0;
    while (hst_ack !== 1'b0 && t < 60) begin @(negedge clk); t++; end
    if (t >= 60) xfer_errs++;
    t = 0;
    while (hst_ack !== 1'b1 && t < 400) begin @(negedge clk); t++; end
    if (t >= 400) xfer_errs++;
    q = hst_ad_o;
    last_oe = hst_ad_oe;
    hst_sel_n = 1'b1; hst_rd_n = 1'b1; hst_wr_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic pm_write(input logic [23:0] v, input logic [7:0] junk);
    logic [15:0] q;
    xfer(1'b1, v[23:8], q);
    xfer(1'b1, {junk, v[7:0]}, q);
  endtask

  task automatic pm_read(output logic [15:0] hi, output logic [15:0] lo);
    xfer(1'b0, 16'h0, hi);
    xfer(1'b0, 16'h0, lo);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=%h expected=%h", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] q, hi, lo;
    logic [15:0] vals [4];
    logic [23:0] pv [4];
    int t, c0;
    void'($urandom(32'd4711));
    rst = 1'b1;
    hst_latch = 1'b0; hst_sel_n = 1'b1; hst_rd_n = 1'b1; hst_wr_n = 1'b1;
    hst_ad_i = '0;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk("R1 ack", 24'(hst_ack), 24'd1);
    chk("R1 req", 24'(mem_req), 24'd0);
    chk("R1 oe", 24'(hst_ad_oe), 24'd0);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    // R5/R7: data burst write
    latch(1'b0, 14'h0100, 1'b0);
    for (int i = 0; i < 4; i++) begin
      vals[i] = 16'($urandom);
      xfer(1'b1, vals[i], q);
    end
    for (int i = 0; i < 4; i++)
      chk("R5 R7 dm write", mget(1'b0, 14'(14'h0100 + i)), {8'h00, vals[i]});
    // R6/R11: read back
    latch(1'b0, 14'h0100, 1'b0);
    for (int i = 0; i < 4; i++) begin
      xfer(1'b0, 16'h0, q);
      chk("R6 dm read", 24'(q), 24'(vals[i]));
      chk("R11 oe at ack", 24'(last_oe), 24'd1);
    end
    chk("R11 oe released", 24'(hst_ad_oe), 24'd0);
    // R6: preloaded contents
    latch(1'b0, 14'h0777, 1'b0);
    xfer(1'b0, 16'h0, q);
    chk("R6 dm preload", 24'(q), pat(1'b0, 14'h0777));

    // R7: wrap
    latch(1'b0, 14'h3FFE, 1'b0);
    xfer(1'b1, 16'h1111, q);
    xfer(1'b1, 16'h2222, q);
    xfer(1'b1, 16'h3333, q);
    chk("R7 wrap 3FFE", mget(1'b0, 14'h3FFE), 24'h001111);
    chk("R7 wrap 3FFF", mget(1'b0, 14'h3FFF), 24'h002222);
    chk("R7 wrap 0000", mget(1'b0, 14'h0000), 24'h003333);

    // R2: bit 15 ignored, bit 14 picks space
    latch(1'b0, 14'h0030, 1'b1);
    xfer(1'b1, 16'hBEEF, q);
    chk("R2 bit15 ignored", mget(1'b0, 14'h0030), 24'h00BEEF);
    chk("R2 pm untouched", mget(1'b1, 14'h0030), pat(1'b1, 14'h0030));

    // R8: program write pairs
    latch(1'b1, 14'h0020, 1'b0);
    c0 = wr_cnt;
    xfer(1'b1, 16'hA1B2, q);
    chk("R8 no write on upper half", 24'(wr_cnt - c0), 24'd0);
    xfer(1'b1, 16'hFFC3, q);
    chk("R8 one write per word", 24'(wr_cnt - c0), 24'd1);
    pm_write(24'h445566, 8'h9A);
    chk("R8 pm word0", mget(1'b1, 14'h0020), 24'hA1B2C3);
    chk("R8 pm word1", mget(1'b1, 14'h0021), 24'h445566);

    // R9: program read pairs
    latch(1'b1, 14'h0020, 1'b0);
    c0 = rd_cnt;
    pm_read(hi, lo);
    chk("R9 pm hi", 24'(hi), 24'h00A1B2);
    chk("R9 pm lo", 24'(lo), 24'h0000C3);
    chk("R9 one read per word", 24'(rd_cnt - c0), 24'd1);
    pm_read(hi, lo);
    chk("R9 pm next hi", 24'(hi), 24'h004455);
    chk("R9 pm next lo", 24'(lo), 24'h000066);

    // R12: relatch restarts pairing
    latch(1'b1, 14'h0040, 1'b0);
    xfer(1'b1, 16'h7777, q);
    latch(1'b1, 14'h0040, 1'b0);
    pm_write(24'h223344, 8'h00);
    chk("R12 pairing restart", mget(1'b1, 14'h0040), 24'h223344);

    // R3/R10: latch while busy, grant held back
    latch(1'b0, 14'h0200, 1'b0);
    gnt_hold = 1'b1;
    @(negedge clk);
    hst_ad_i = 16'hAAAA; hst_sel_n = 1'b0; hst_wr_n = 1'b0;
    t = 0;
    while (hst_ack !== 1'b0 && t < 60) begin @(negedge clk); t++; end
    hst_ad_i = {1'b0, 1'b1, 14'h1234};
    hst_latch = 1'b1;
    repeat (4) @(negedge clk);
    hst_latch = 1'b0;
    repeat (6) @(negedge clk);
    chk("R10 req held", 24'(mem_req), 24'd1);
    chk("R10 addr held", 24'(mem_addr), 24'h000200);
    chk("R10 data held", mem_wdata, 24'h00AAAA);
    chk("R4 ack low while busy", 24'(hst_ack), 24'd0);
    gnt_hold = 1'b0;
    t = 0;
    while (hst_ack !== 1'b1 && t < 400) begin @(negedge clk); t++; end
    hst_sel_n = 1'b1; hst_wr_n = 1'b1;
    repeat (6) @(negedge clk);
    xfer(1'b1, 16'hBBBB, q);
    chk("R3 first write", mget(1'b0, 14'h0200), 24'h00AAAA);
    chk("R3 latch ignored", mget(1'b0, 14'h0201), 24'h00BBBB);

    // random bursts in both spaces
    for (int it = 0; it < 40; it++) begin
      bit pm;
      logic [13:0] base;
      int n;
      pm = bit'($urandom % 2);
      base = 14'($urandom);
      n = 1 + int'($urandom % 4);
      latch(pm, base, bit'($urandom % 2));
      for (int i = 0; i < n; i++) begin
        if (pm) begin
          pv[i] = 24'($urandom);
          pm_write(pv[i], 8'($urandom));
        end else begin
          vals[i] = 16'($urandom);
          xfer(1'b1, vals[i], q);
        end
      end
      latch(pm, base, 1'b0);
      for (int i = 0; i < n; i++) begin
        if (pm) begin
          pm_read(hi, lo);
          chk("R8 R9 rand pm hi", 24'(hi), 24'(pv[i][23:8]));
          chk("R8 R9 rand pm lo", 24'(lo), 24'(pv[i][7:0]));
          chk("R7 R8 rand pm mem", mget(1'b1, 14'(base + i)), pv[i]);
        end else begin
          xfer(1'b0, 16'h0, q);
          chk("R5 R6 rand dm", 24'(q), 24'(vals[i]));
          chk("R5 R7 rand dm mem", mget(1'b0, 14'(base + i)), {8'h00, vals[i]});
        end
      end
    end

    chk("R4 ack handshake", 24'(xfer_errs), 24'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule